// File: doc/BRIEF.md
# Guarded Flash Read/Write Port

This block sits between a processor bus and an on-chip flash array. It serves instruction fetches, data reads and writes. Each read is stretched to a programmable number of clock cycles so that slow flash has time to settle. Writes always complete at once. A three-bit read-speed code, held in a small configuration register, picks the stretch. Its encoding is not monotonic: the fastest setting sits above the slower ones.

Four consecutive 16 KB windows, starting at byte address 0x8000, can be locked. Two guard words stored in the flash itself control the locks, one for writes and one for data reads. The block copies those words into internal flops once, straight after reset, before any bus access can complete. A blocked write leaves flash untouched. A blocked data read returns zero. Either one completes normally and raises a violation flag for the cycle in which it completes. Instruction fetches ignore the read locks. If the boot-valid bit of the read-guard word is clear, the port reports a failed boot and serves no access at all.

The bus encodes the access kind in two bits: `00` is an instruction fetch, `01` is a data read, and `1x` is a write. A request is held, with its address and data stable, until `ready` is seen high. The flash is a behavioural model. Its two guard words live in dedicated cells, and all other addresses fold onto a parameterised word array.

Top module: `flashGate`

## Requirements
- R1: With read-speed code 0, 1, 2, 3 or 4, a fetch or data read completes (`ready` high) in cycle 2, 3, 4, 5 or 1 respectively. The cycle in which the request is first presented counts as cycle 1.
- R2: After reset the read-speed code is 3, so reads complete in cycle 5.
- R3: Read-speed codes 5, 6 and 7 behave like the slowest setting and complete reads in cycle 5.
- R4: A write (kind bit 1 set) completes in the cycle it is presented. The word is stored at the clock edge that ends that cycle and can be read back afterwards.
- R5: Bit i of the write-guard word (byte address 0x27FFC) unlocks the 16 KB window at 0x8000 + i*0x4000 when it is 1 and locks it when it is 0. A write to a locked window still completes in one cycle, leaves the flash word unchanged and raises `violation` in that cycle.
- R6: Bits 1 to 3 of the read-guard word (byte address 0x27FFE) unlock data reads of the windows at 0xC000, 0x10000 and 0x14000 when they are 1. A data read (kind `01`) of a locked window completes with normal timing, returns 0x0000 and raises `violation`. The window at 0x8000 is never read-locked.
- R7: Instruction fetches (kind `00`) from a read-locked window return the stored word without `violation`. Addresses outside the four windows are never locked.
- R8: The guard words are copied from flash only after reset. Changing the guard cells by a write has no effect until the next reset. No access completes during reset or in the first cycle after reset is released.
- R9: If bit 0 of the read-guard word is 0 when it is copied, `bootFail` goes high and no access ever completes until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request, held until ready |
| reqKind | input | 2 | 00 fetch, 01 data read, 1x write |
| reqAddr | input | ADDR_W | Byte address (bit 0 ignored by the array) |
| reqWdata | input | DATA_W | Write data |
| ready | output | 1 | Access completes in this cycle |
| rdata | output | DATA_W | Read data, valid with ready; zero otherwise |
| violation | output | 1 | Completing access hit a locked window |
| cfgWe | input | 1 | Load the read-speed code |
| cfgCode | input | 3 | New read-speed code |
| bootFail | output | 1 | Boot-valid bit was found clear |

## Verification
The bench builds the port with a 256-word array and with initial guard words 0xFFF5 and 0xFFFB. From the very first boot, the windows at 0xC000 and 0x14000 are therefore write-locked and the window at 0x10000 is data-read-locked. The small array keeps every test address on its own word. Because the guard cells are ordinary writable flash, the bench can rewrite them and reset again. That lets it show that locked windows open only after a reset and close again after the next one. As its last step it clears the boot-valid bit and reaches the failed-boot state.

// File: rtl/flashGatePkg.sv
`timescale 1ns/1ps
package flashGatePkg;

  localparam int CODE_W = 3;
  localparam int CYC_W  = 3;

  typedef enum logic {
    ST_LOAD,
    ST_LIVE
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadGuards;
    logic finish;
  } ctrlStrobes_t;

  // non-monotonic speed code; anything unknown falls back to the slowest
  function automatic logic [CYC_W-1:0] decodeReadCycles(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 3'd2;
      3'd1:    return 3'd3;
      3'd2:    return 3'd4;
      3'd4:    return 3'd1;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/flashArrayModel.sv
`timescale 1ns/1ps
module flashArrayModel #(
  parameter int WORD_ADDR_W = 17,
  parameter int DATA_W      = 16,
  parameter int FLASH_WORDS = 1024,
  parameter int GUARD_BITS  = 4,
  parameter logic [WORD_ADDR_W-1:0] WP_WORD = '1,
  parameter logic [WORD_ADDR_W-1:0] RP_WORD = '1,
  parameter logic [DATA_W-1:0] INIT_WP = '1,
  parameter logic [DATA_W-1:0] INIT_RP = '1
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [WORD_ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [GUARD_BITS-1:0]  wpBits,
  output logic [GUARD_BITS-1:0]  rpBits
);

  localparam int IDX_W = $clog2(FLASH_WORDS);

  logic [DATA_W-1:0] cells [FLASH_WORDS];
  logic [DATA_W-1:0] wpCell = INIT_WP;
  logic [DATA_W-1:0] rpCell = INIT_RP;

  logic hitWp, hitRp;
  logic [IDX_W-1:0] idx;

  assign hitWp = (wordAddr == WP_WORD);
  assign hitRp = (wordAddr == RP_WORD);
  assign idx   = wordAddr[IDX_W-1:0];

  // non-volatile storage: no reset
  always_ff @(posedge clk) begin
    if (we) begin
      if (hitWp)      wpCell     <= wdata;
      else if (hitRp) rpCell     <= wdata;
      else            cells[idx] <= wdata;
    end
  end

  always_comb begin
    if (hitWp)      rdata = wpCell;
    else if (hitRp) rdata = rpCell;
    else            rdata = cells[idx];
  end

  assign wpBits = wpCell[GUARD_BITS-1:0];
  assign rpBits = rpCell[GUARD_BITS-1:0];

endmodule

// File: rtl/flashGateCtrl.sv
`timescale 1ns/1ps
module flashGateCtrl
  import flashGatePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsWrite,
  input  logic [CYC_W-1:0] readCycles,
  input  logic             bootGood,
  output ctrlStrobes_t     strobes,
  output logic             running,
  output logic             bootFail
);

  ctrlState_e state;
  logic [CYC_W-1:0] waitCnt;
  logic finishNow;
  logic serving;

  assign running  = (state == ST_LIVE);
  assign serving  = running && bootGood && reqValid;
  assign bootFail = running && !bootGood;

  always_comb begin
    finishNow = 1'b0;
    if (serving)
      finishNow = reqIsWrite || (waitCnt >= readCycles - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      waitCnt <= '0;
    end else begin
      state <= ST_LIVE;
      if (finishNow)
        waitCnt <= '0;
      else if (serving && !reqIsWrite)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  assign strobes.loadGuards = (state == ST_LOAD);
  assign strobes.finish     = finishNow;

endmodule

// File: rtl/flashGateData.sv
`timescale 1ns/1ps
module flashGateData
  import flashGatePkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int NUM_REGIONS = 4,
  parameter int unsigned REGION_BASE  = 32'h8000,
  parameter int unsigned REGION_BYTES = 32'h4000,
  parameter int READ_GUARD_LSB = 1,
  parameter logic [CODE_W-1:0] RESET_CODE = 3'd3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [1:0]             reqKind,
  input  logic                   cfgWe,
  input  logic [CODE_W-1:0]      cfgCode,
  input  logic [DATA_W-1:0]      flashRdata,
  input  logic [NUM_REGIONS-1:0] flashWpBits,
  input  logic [NUM_REGIONS-1:0] flashRpBits,
  output logic [CYC_W-1:0]       readCycles,
  output logic                   bootGood,
  output logic                   flashWe,
  output logic [DATA_W-1:0]      rdata,
  output logic                   violation
);

  logic [CODE_W-1:0]      cycleCode;
  logic [NUM_REGIONS-1:0] writeOk;
  logic [NUM_REGIONS-1:0] readMask;
  logic [NUM_REGIONS-1:0] hitRegion;
  logic bootFlag;
  logic isWrite, isDataRead, writeBlocked, readBlocked, blocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cycleCode <= RESET_CODE;
    else if (cfgWe) cycleCode <= cfgCode;
  end

  assign readCycles = decodeReadCycles(cycleCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeOk  <= '1;
      bootFlag <= 1'b1;
    end else if (strobes.loadGuards) begin
      writeOk  <= flashWpBits;
      bootFlag <= flashRpBits[0];
    end
  end

  assign bootGood = bootFlag;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : gRegion
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(REGION_BASE + i * REGION_BYTES);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(REGION_BASE + (i + 1) * REGION_BYTES);
    assign hitRegion[i] = (reqAddr >= LO) && (reqAddr < HI);

    if (i < READ_GUARD_LSB) begin : gOpen
      assign readMask[i] = 1'b1;
    end else begin : gGuard
      logic okQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   okQ <= 1'b1;
        else if (strobes.loadGuards) okQ <= flashRpBits[i];
      end
      assign readMask[i] = okQ;
    end
  end

  assign isWrite      = reqKind[1];
  assign isDataRead   = !reqKind[1] && reqKind[0];
  assign writeBlocked = |(hitRegion & ~writeOk);
  assign readBlocked  = |(hitRegion & ~readMask);
  assign blocked      = isWrite ? writeBlocked : (isDataRead && readBlocked);

  assign flashWe   = strobes.finish && isWrite && !writeBlocked;
  assign violation = strobes.finish && blocked;
  assign rdata     = (strobes.finish && !isWrite && !blocked) ? flashRdata : '0;

endmodule

// File: rtl/flashGate.sv
`timescale 1ns/1ps
module flashGate
  import flashGatePkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int NUM_REGIONS = 4,
  parameter int unsigned REGION_BASE  = 32'h8000,
  parameter int unsigned REGION_BYTES = 32'h4000,
  parameter int READ_GUARD_LSB = 1,
  parameter int unsigned WP_ADDR = 32'h27FFC,
  parameter int unsigned RP_ADDR = 32'h27FFE,
  parameter int FLASH_WORDS = 1024,
  parameter logic [DATA_W-1:0] INIT_WP = '1,
  parameter logic [DATA_W-1:0] INIT_RP = '1,
  parameter logic [2:0] RESET_CODE = 3'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              violation,
  input  logic              cfgWe,
  input  logic [2:0]        cfgCode,
  output logic              bootFail
);

  localparam int WORD_ADDR_W = ADDR_W - 1;
  localparam logic [WORD_ADDR_W-1:0] WP_WORD = WORD_ADDR_W'(WP_ADDR >> 1);
  localparam logic [WORD_ADDR_W-1:0] RP_WORD = WORD_ADDR_W'(RP_ADDR >> 1);

  ctrlStrobes_t strobes;
  logic running;
  logic bootGood;
  logic flashWe;
  logic [CYC_W-1:0] readCycles;
  logic [DATA_W-1:0] flashRdata;
  logic [NUM_REGIONS-1:0] flashWpBits, flashRpBits;

  flashGateCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqIsWrite(reqKind[1]),
    .readCycles(readCycles),
    .bootGood  (bootGood),
    .strobes   (strobes),
    .running   (running),
    .bootFail  (bootFail)
  );

  flashGateData #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .NUM_REGIONS   (NUM_REGIONS),
    .REGION_BASE   (REGION_BASE),
    .REGION_BYTES  (REGION_BYTES),
    .READ_GUARD_LSB(READ_GUARD_LSB),
    .RESET_CODE    (RESET_CODE)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .reqKind    (reqKind),
    .cfgWe      (cfgWe),
    .cfgCode    (cfgCode),
    .flashRdata (flashRdata),
    .flashWpBits(flashWpBits),
    .flashRpBits(flashRpBits),
    .readCycles (readCycles),
    .bootGood   (bootGood),
    .flashWe    (flashWe),
    .rdata      (rdata),
    .violation  (violation)
  );

  flashArrayModel #(
    .WORD_ADDR_W(WORD_ADDR_W),
    .DATA_W     (DATA_W),
    .FLASH_WORDS(FLASH_WORDS),
    .GUARD_BITS (NUM_REGIONS),
    .WP_WORD    (WP_WORD),
    .RP_WORD    (RP_WORD),
    .INIT_WP    (INIT_WP),
    .INIT_RP    (INIT_RP)
  ) uFlash (
    .clk     (clk),
    .we      (flashWe),
    .wordAddr(reqAddr[ADDR_W-1:1]),
    .wdata   (reqWdata),
    .rdata   (flashRdata),
    .wpBits  (flashWpBits),
    .rpBits  (flashRpBits)
  );

  assign ready = strobes.finish;

endmodule

// File: rtl/flashGateChecker.sv
`timescale 1ns/1ps
module flashGateChecker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic              ready,
  input logic              violation,
  input logic [DATA_W-1:0] rdata,
  input logic              running,
  input logic              bootFail,
  input logic [2:0]        readCycles
);

  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !ready); // R8

  AST_WRITE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    running && !bootFail && reqValid && reqKind[1] |-> ready); // R4

  AST_READ_HAS_WAITED: assert property (@(posedge clk) disable iff (!rstN)
    ready && !reqKind[1] && readCycles > 3'd1 |-> $past(reqValid) && !$past(ready)); // R1

  AST_READ_CYCLE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    readCycles >= 3'd1 && readCycles <= 3'd5); // R3

  AST_VIOLATION_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> ready); // R5

  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    violation && !reqKind[1] |-> rdata == '0); // R6

  AST_FETCH_NO_VIOLATION: assert property (@(posedge clk) disable iff (!rstN)
    ready && reqKind == 2'b00 |-> !violation); // R7

  AST_FAILED_BOOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    bootFail |-> !ready); // R9

endmodule

bind flashGate flashGateChecker #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqKind   (reqKind),
  .ready     (ready),
  .violation (violation),
  .rdata     (rdata),
  .running   (running),
  .bootFail  (bootFail),
  .readCycles(readCycles)
);

// File: tb/flashGate_test.sv
`timescale 1ns/1ps
module flashGate_test;

  localparam int ADDR_W = 18;
  localparam int DATA_W = 16;
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_DREAD = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgCode = 3'd0;
  logic ready, violation, bootFail;
  logic [DATA_W-1:0] rdata;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  flashGate #(
    .FLASH_WORDS(256),
    .INIT_WP    (16'hFFF5),
    .INIT_RP    (16'hFFFB)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .ready    (ready),
    .rdata    (rdata),
    .violation(violation),
    .cfgWe    (cfgWe),
    .cfgCode  (cfgCode),
    .bootFail (bootFail)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // cyc = cycle of completion (1 = presentation cycle), 99 = never
  task automatic access(input logic [1:0] kind, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] wd, output int cyc,
                        output logic [DATA_W-1:0] rd, output logic viol);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqWdata = wd;
    cyc = 1;
    #1;
    while (!ready && cyc < 20) begin
      @(negedge clk); #1; cyc++;
    end
    if (!ready) cyc = 99;
    rd = rdata; viol = violation;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic setCode(input logic [2:0] c);
    @(negedge clk); cfgWe = 1'b1; cfgCode = c;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready == 1'b0, "R8 ready in reset", int'(ready), 0);
    check(violation == 1'b0, "R8 violation in reset", int'(violation), 0);
    check(bootFail == 1'b0, "R9 bootFail in reset", int'(bootFail), 0);
    reqValid = 1'b1; reqKind = K_WRITE; reqAddr = 18'h00050; reqWdata = 16'h0;
    rstN = 1'b1;
    #1;
    check(ready == 1'b0, "R8 ready first cycle after reset", int'(ready), 0);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tResetSpeed();
    int c; logic [DATA_W-1:0] d; logic v;
    access(K_WRITE, 18'h00050, 16'h1111, c, d, v);
    check(c == 1, "R4 write cycles", c, 1);
    access(K_FETCH, 18'h00050, 16'h0, c, d, v);
    check(c == 5, "R2 reset read cycles", c, 5);
    check(d == 16'h1111, "R4 write readback", int'(d), 'h1111);
  endtask

  task automatic tCodes();
    int c; logic [DATA_W-1:0] d; logic v;
    int expCyc [8] = '{2, 3, 4, 5, 1, 5, 5, 5};
    for (int k = 0; k < 8; k++) begin
      setCode(3'(k));
      access(K_FETCH, 18'h00050, 16'h0, c, d, v);
      if (k < 5) check(c == expCyc[k], "R1 fetch cycles per code", c, expCyc[k]);
      else       check(c == expCyc[k], "R3 reserved code cycles", c, expCyc[k]);
      check(d == 16'h1111, "R1 fetch data", int'(d), 'h1111);
    end
    setCode(3'd2);
    access(K_DREAD, 18'h00050, 16'h0, c, d, v);
    check(c == 4, "R1 data read cycles code 2", c, 4);
    check(d == 16'h1111 && !v, "R1 data read value", int'(d), 'h1111);
  endtask

  task automatic tWrite();
    int c; logic [DATA_W-1:0] d; logic v;
    access(K_WRITE, 18'h08010, 16'hA5A5, c, d, v);
    check(c == 1 && !v, "R4 write open window", c, 1);
    access(K_DREAD, 18'h08010, 16'h0, c, d, v);
    check(d == 16'hA5A5 && !v, "R6 first window never read-locked", int'(d), 'hA5A5);
  endtask

  task automatic tWriteGuard();
    int c; logic [DATA_W-1:0] d; logic v;
    access(K_WRITE, 18'h0C020, 16'hBEEF, c, d, v);
    check(v == 1'b1, "R5 locked write violation", int'(v), 1);
    check(c == 1, "R5 locked write cycles", c, 1);
    access(K_WRITE, 18'h27FFC, 16'hFFFF, c, d, v);
    check(!v, "R7 guard cell write outside windows", int'(v), 0);
    access(K_WRITE, 18'h0C020, 16'hBEEF, c, d, v);
    check(v == 1'b1, "R8 guard change waits for reset", int'(v), 1);
    pulseReset();
    access(K_WRITE, 18'h0C020, 16'h1234, c, d, v);
    check(!v, "R8 window opened after reset", int'(v), 0);
    access(K_WRITE, 18'h14040, 16'h5678, c, d, v);
    check(!v, "R8 last window opened after reset", int'(v), 0);
    access(K_WRITE, 18'h27FFC, 16'hFFF5, c, d, v);
    pulseReset();
    access(K_WRITE, 18'h0C020, 16'hBEEF, c, d, v);
    check(v == 1'b1, "R5 window relocked", int'(v), 1);
    access(K_DREAD, 18'h0C020, 16'h0, c, d, v);
    check(d == 16'h1234 && !v, "R5 locked write left word unchanged", int'(d), 'h1234);
    access(K_WRITE, 18'h14040, 16'h0000, c, d, v);
    check(v == 1'b1, "R5 last window locked", int'(v), 1);
    access(K_FETCH, 18'h14040, 16'h0, c, d, v);
    check(d == 16'h5678, "R5 last window unchanged", int'(d), 'h5678);
  endtask

  task automatic tReadGuard();
    int c; logic [DATA_W-1:0] d; logic v;
    access(K_WRITE, 18'h10030, 16'h4321, c, d, v);
    check(!v, "R5 third window writable", int'(v), 0);
    access(K_DREAD, 18'h10030, 16'h0, c, d, v);
    check(d == 16'h0000, "R6 locked data read returns zero", int'(d), 0);
    check(v == 1'b1, "R6 locked data read violation", int'(v), 1);
    check(c == 5, "R6 locked data read timing", c, 5);
    access(K_FETCH, 18'h10030, 16'h0, c, d, v);
    check(d == 16'h4321 && !v, "R7 fetch ignores read lock", int'(d), 'h4321);
    access(K_WRITE, 18'h18060, 16'h7777, c, d, v);
    check(!v, "R7 write beyond windows", int'(v), 0);
    access(K_DREAD, 18'h18060, 16'h0, c, d, v);
    check(d == 16'h7777 && !v, "R7 data read beyond windows", int'(d), 'h7777);
  endtask

  task automatic tBootFail();
    int c; logic [DATA_W-1:0] d; logic v;
    access(K_WRITE, 18'h27FFE, 16'hFFFA, c, d, v);
    pulseReset();
    repeat (2) @(negedge clk);
    check(bootFail == 1'b1, "R9 bootFail raised", int'(bootFail), 1);
    access(K_FETCH, 18'h00050, 16'h0, c, d, v);
    check(c == 99, "R9 no access completes", c, 99);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    tReset();
    tResetSpeed();
    tCodes();
    tWrite();
    tWriteGuard();
    tReadGuard();
    tBootFail();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule